// File: doc/BRIEF.md
# Prescaled Seconds Countdown Timer

This block is the timing datapath that sits beside a traffic-light sequencer. A wide cycle prescaler divides the system clock down to a one-cycle "second" tick. A small down-counter is loaded with a requested duration in seconds and steps down by one after each tick. When it reaches zero it raises a done flag for the sequencer. The current count is also brought out so that a display driver can show the remaining seconds.

The sequencer pulses `init_i` to start an interval. That pulse loads `dur_i` and restarts the prescaler, so the first second always lasts a full period. While `en_i` is high the prescaler advances and the count steps down. While `en_i` is low the timer freezes. The number of clock cycles per second is the parameter `CYC_PER_SEC`, which must be at least 2. Its default of 100,000,000 suits a 100 MHz clock, and simulation can use a small value.

Top module: `sec_countdown`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `count_o` is 0, `done_o` is 1 and `tick_o` is 0.
- R2: A cycle with `init_i` high loads `dur_i` into `count_o` at the next clock edge, whatever the level of `en_i`. That same edge clears `tick_o` and restarts the prescaler.
- R3: Once `init_i` has fallen, `tick_o` is high for exactly one cycle after every `CYC_PER_SEC` clock edges taken with `en_i` high. The first tick comes after the `CYC_PER_SEC`-th such edge.
- R4: At a clock edge where `tick_o` and `en_i` are both high, `init_i` is low and `count_o` is non-zero, `count_o` decreases by exactly one.
- R5: `done_o` is 1 exactly when `count_o` is 0.
- R6: When `count_o` is 0 it stays at 0 and does not wrap. Ticks keep arriving while `en_i` is high.
- R7: At an edge where `en_i` and `init_i` are both low, the prescaler and `count_o` hold their values and `tick_o` is 0 after that edge.
- R8: An `init_i` pulse in the middle of an interval restarts the prescaler, so the next tick comes a full `CYC_PER_SEC` enabled edges later.
- R9: A tick that coincides with `en_i` low is lost: `count_o` does not change at that edge, and the next tick follows a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Load strobe: takes `dur_i` and restarts the prescaler |
| en_i | input | 1 | Count enable for both stages |
| dur_i | input | CNT_W | Duration in seconds to load |
| tick_o | output | 1 | One-cycle seconds tick from the prescaler |
| done_o | output | 1 | High while the remaining count is zero |
| count_o | output | CNT_W | Remaining seconds, for display |

## Verification
The bench uses a prescale of five and sweeps every duration from 0 to 15. Every cycle it compares the tick, the count and done against a closed-form function of the number of enabled edges since the load. A prescaler that is off by one would drift the tick away from every fifth edge. A counter that wraps at zero would show 15 after a load of 0. Further scenarios freeze the timer in mid-second, drop enable just as a tick is present, and reload partway through an interval. A design that keeps counting while frozen, or that decrements on a lost tick, or that keeps the old prescaler phase after a reload, would move every later decrement by whole cycles.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;

  // Operation selected for the seconds register in one cycle
  typedef enum logic [1:0] {
    SEC_HOLD = 2'd0,
    SEC_LOAD = 2'd1,
    SEC_DEC  = 2'd2
  } sec_op_e;

endpackage

// File: rtl/cycle_prescaler.sv
module cycle_prescaler #(
  parameter int CYC_PER_SEC = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int PRE_W = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CYC_PER_SEC - 1);

  logic [PRE_W-1:0] pre_q;
  logic             tick_q;
  logic             wrap;

  assign wrap = (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pre_q  <= '0;
      tick_q <= 1'b0;
    end else if (en_i) begin
      pre_q  <= wrap ? '0 : pre_q + 1'b1;
      tick_q <= wrap;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/sec_downcounter.sv
module sec_downcounter
  import sec_timer_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  sec_op_e          op;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             zero_q;

  always_comb begin
    if (load_i)                      op = SEC_LOAD;
    else if (step_i && cnt_q != '0)  op = SEC_DEC;
    else                             op = SEC_HOLD;
  end

  always_comb begin
    unique case (op)
      SEC_LOAD: cnt_d = val_i;
      SEC_DEC:  cnt_d = cnt_q - 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      zero_q <= (cnt_d == '0);
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = zero_q;
endmodule

// File: rtl/sec_countdown.sv
module sec_countdown #(
  parameter int CYC_PER_SEC = 100_000_000,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             tick_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic tick;
  logic step;

  cycle_prescaler #(.CYC_PER_SEC(CYC_PER_SEC)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (init_i),
    .en_i   (en_i),
    .tick_o (tick)
  );

  assign step = tick && en_i;

  sec_downcounter #(.CNT_W(CNT_W)) u_sec (
    .clk    (clk),
    .rst    (rst),
    .load_i (init_i),
    .step_i (step),
    .val_i  (dur_i),
    .cnt_o  (count_o),
    .zero_o (done_o)
  );

  assign tick_o = tick;
endmodule

// File: rtl/sec_countdown_chk.sv
module sec_countdown_chk #(
  parameter int CYC_PER_SEC = 100_000_000,
  parameter int CNT_W       = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             init_i,
  input logic             en_i,
  input logic [CNT_W-1:0] dur_i,
  input logic             tick_o,
  input logic             done_o,
  input logic [CNT_W-1:0] count_o
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (count_o == '0 && done_o && !tick_o)); // R1
  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (rst) init_i |=> (count_o == $past(dur_i) && !tick_o)); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst) tick_o |=> !tick_o); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst) (tick_o && en_i && !init_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1)); // R4
  AST_DONE_MATCH: assert property (@(posedge clk) disable iff (rst) done_o == (count_o == '0)); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst) (count_o == '0 && !init_i) |=> count_o == '0); // R6
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst) (!en_i && !init_i) |=> ($stable(count_o) && !tick_o)); // R7
  AST_LOST_TICK: assert property (@(posedge clk) disable iff (rst) (!init_i && !(tick_o && en_i)) |=> $stable(count_o)); // R9
endmodule

bind sec_countdown sec_countdown_chk #(.CYC_PER_SEC(CYC_PER_SEC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .init_i(init_i), .en_i(en_i), .dur_i(dur_i),
  .tick_o(tick_o), .done_o(done_o), .count_o(count_o)
);

// File: tb/tb_sec_countdown.sv
module tb_sec_countdown;
  localparam int C = 5;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         init_i = 1'b0;
  logic         en_i = 1'b0;
  logic [W-1:0] dur_i = '0;
  logic         tick_o;
  logic         done_o;
  logic [W-1:0] count_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sec_countdown #(.CYC_PER_SEC(C), .CNT_W(W)) dut (
    .clk(clk), .rst(rst), .init_i(init_i), .en_i(en_i), .dur_i(dur_i),
    .tick_o(tick_o), .done_o(done_o), .count_o(count_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected count after k enabled edges since a load of d (no lost ticks)
  function automatic int exp_cnt(input int d, input int k);
    int n;
    n = (k >= 1) ? (k - 1) / C : 0;
    return (d - n > 0) ? d - n : 0;
  endfunction

  // Load d with en high; after return, k = 0 has been observed
  task automatic load(input int d, input string req);
    dur_i  = W'(d);
    init_i = 1'b1;
    en_i   = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
    chk({req, " load count"}, int'(count_o), d);
    chk({req, " load tick"}, int'(tick_o), 0);
    chk("R5 done after load", int'(done_o), (d == 0) ? 1 : 0);
  endtask

  // Run enabled edges k0..k1, comparing with the closed form (offset in ticks lost)
  task automatic run(input int d, input int k0, input int k1, input int lost);
    for (int k = k0; k <= k1; k++) begin
      int e;
      @(negedge clk);
      e = exp_cnt(d + lost, k);
      if (e > d) e = d;
      chk("R3 tick spacing", int'(tick_o), (k >= C && k % C == 0) ? 1 : 0);
      chk((e == 0) ? "R6 saturate" : "R4 decrement", int'(count_o), e);
      chk("R5 done", int'(done_o), (e == 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset done", int'(done_o), 1);
    chk("R1 reset tick", int'(tick_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset count", int'(count_o), 0);
    chk("R1 after reset done", int'(done_o), 1);

    // R2 load with enable low, nothing moves afterwards
    dur_i = 4'd7; init_i = 1'b1; en_i = 1'b0;
    @(negedge clk);
    init_i = 1'b0;
    chk("R2 load with en low", int'(count_o), 7);
    repeat (2 * C) begin
      @(negedge clk);
      chk("R7 frozen count", int'(count_o), 7);
      chk("R7 frozen tick", int'(tick_o), 0);
    end

    // Sweep all durations
    for (int d = 0; d < 16; d++) begin
      load(d, "R2");
      run(d, 1, d * C + 2 * C, 0);
    end

    // R7 pause mid-second (k = 7, not a tick edge)
    load(9, "R2");
    run(9, 1, 7, 0);
    en_i = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk("R7 pause count", int'(count_o), exp_cnt(9, 7));
      chk("R7 pause tick", int'(tick_o), 0);
    end
    en_i = 1'b1;
    run(9, 8, 30, 0);

    // R9 tick lost with enable low
    load(4, "R2");
    run(4, 1, 5, 0);
    en_i = 1'b0;
    @(negedge clk);
    chk("R9 lost tick count", int'(count_o), 4);
    chk("R9 lost tick tick", int'(tick_o), 0);
    en_i = 1'b1;
    // prescaler resumes from phase 0 after edge 5; schedule shifts by one tick
    for (int k = 6; k <= 10; k++) begin
      @(negedge clk);
      chk("R9 held count", int'(count_o), 4);
      chk("R9 next tick", int'(tick_o), (k == 10) ? 1 : 0);
    end
    @(negedge clk);
    chk("R9 decrement after full period", int'(count_o), 3);

    // R8 reload mid-interval restarts the prescaler
    load(10, "R2");
    run(10, 1, 8, 0);
    load(6, "R8");
    run(6, 1, 4 * C, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule